// File: doc/BRIEF.md
# Dual-Source Configuration Register Router

This block gives two requesters access to one configuration word space. A local host drives a memory-mapped slave port that has a wait-request and pipelined reads, each answered by a one-cycle read-valid strobe. A remote maintenance stream arrives already decoded into single read or write operations with a valid/ready handshake, and every one of them gets one response pulse.

A small internal register file covers one window of word addresses. Local and remote accesses that fall in that window contend for the register file through a round-robin arbiter, one grant per cycle. A remote access outside the window goes out on a memory-mapped master port to user logic, and the master's response is passed back to the remote requester. A local access outside the window never leaves the block: a read returns an error and a write is discarded. Every word is 32 bits and is always accessed whole. Word addresses are 22 bits wide, which spans a 24-bit byte space (byte address = word address << 2).

Top module: `cfg_route_top`

## Requirements
- R1: While reset is asserted and right after it, every internal register reads zero, `lcl_rvalid`, `lcl_rerr`, `rsp_valid` and `rsp_err` are low, and `ext_rd` and `ext_wr` are low.
- R2: A local read is accepted on a clock edge where `lcl_rd` is high and `lcl_wait` is low. In the cycle after that edge, `lcl_rvalid` is high for exactly one cycle and carries the word. There is exactly one response per accepted read, so responses come back in order.
- R3: The internal window is the word addresses `REG_BASE` to `REG_BASE+NREGS-1` (default 0x40 to 0x4F). A local write accepted inside the window updates that word, and later reads from either requester return it.
- R4: A local read outside the window completes with `lcl_rerr`=1 and `lcl_rdata`=0. A local write outside the window changes no register and causes no activity on the master port.
- R5: While the local request is not granted, `lcl_wait` is high, and the request is taken only on a later edge where `lcl_wait` is low.
- R6: A remote access inside the window is accepted when `rmt_ready` is high. `rsp_valid` pulses in the next cycle with `rsp_err`=0. For a read, `rsp_rdata` carries the register; for a write, it is 0.
- R7: A remote access outside the window raises `ext_rd` or `ext_wr` with the same address and write data. The command, address and data stay unchanged while `ext_wait` is high. The master port never carries an address inside the window.
- R8: For a forwarded read, the block answers only after `ext_rvalid` and returns `ext_rdata` and `ext_rerr` on `rsp_rdata`/`rsp_err`. A forwarded write is answered (`rsp_err`=0, data 0) in the cycle after the master accepts it. `rmt_ready` stays low while a forward is in progress.
- R9: Local and remote in-window accesses are never granted in the same cycle. When both request at once, the side that did not win the previous grant wins. After reset, the local side wins first.
- R10: `lcl_rerr` is high only together with `lcl_rvalid`, and `rsp_err` only together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lcl_rd | input | 1 | Local read request |
| lcl_wr | input | 1 | Local write request |
| lcl_addr | input | 22 | Local word address |
| lcl_wdata | input | 32 | Local write data |
| lcl_wait | output | 1 | Local request stall |
| lcl_rdata | output | 32 | Local read data |
| lcl_rvalid | output | 1 | Local read data valid pulse |
| lcl_rerr | output | 1 | Local read error, qualified by lcl_rvalid |
| rmt_valid | input | 1 | Remote request valid |
| rmt_write | input | 1 | Remote request is a write |
| rmt_addr | input | 22 | Remote word address |
| rmt_wdata | input | 32 | Remote write data |
| rmt_ready | output | 1 | Remote request accepted this cycle |
| rsp_valid | output | 1 | Remote response pulse |
| rsp_rdata | output | 32 | Remote response data |
| rsp_err | output | 1 | Remote response error, qualified by rsp_valid |
| ext_rd | output | 1 | Master port read command |
| ext_wr | output | 1 | Master port write command |
| ext_addr | output | 22 | Master port word address |
| ext_wdata | output | 32 | Master port write data |
| ext_wait | input | 1 | Master port stall from user logic |
| ext_rdata | input | 32 | Master port read data |
| ext_rvalid | input | 1 | Master port read data valid |
| ext_rerr | input | 1 | Master port read error |

## Verification
The hardest case to reach is a genuine same-cycle contest between both requesters with a known arbitration history. The bench sets that history with a lone access from one side, then launches a local and a remote write to the same word on the same clock edge. The order in which the two are accepted, and the value left in the word, show which side won. A randomly stalling user-logic model answers forwarded reads after a random delay, so the hold-while-stalled and wait-for-read-valid paths are exercised under random ext_wait patterns.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

  typedef enum logic [1:0] {
    RP_IDLE = 2'd0,
    RP_XREQ = 2'd1,
    RP_XRD  = 2'd2
  } rpath_e;

  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input logic [31:0] n);
    return (a >= base) && (a < base + n);
  endfunction

endpackage

// File: rtl/cfg_rr_arb.sv
module cfg_rr_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic req_l,
  input  logic req_r,
  output logic gnt_l,
  output logic gnt_r
);
  logic prio_r_q, prio_r_d, upd;

  assign gnt_l = req_l & (~req_r | ~prio_r_q);
  assign gnt_r = req_r & (~req_l |  prio_r_q);
  assign upd   = gnt_l | gnt_r;

  always_comb begin
    prio_r_d = prio_r_q;
    if (upd) prio_r_d = gnt_l;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prio_r_q <= 1'b0;
    else if (upd) prio_r_q <= prio_r_d;
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_word
    logic en;
    assign en = we && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[g] <= '0;
      else if (en) regs_q[g] <= wdata;
    end
  end

  assign rdata = regs_q[idx];
endmodule

// File: rtl/cfg_rmt_path.sv
module cfg_rmt_path
  import cfg_route_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rmt_valid,
  input  logic              rmt_write,
  input  logic [ADDR_W-1:0] rmt_addr,
  input  logic [DATA_W-1:0] rmt_wdata,
  input  logic              hit,
  input  logic              gnt,
  input  logic [DATA_W-1:0] int_rdata,
  output logic              req_int,
  output logic              rmt_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic              ext_wait,
  input  logic [DATA_W-1:0] ext_rdata,
  input  logic              ext_rvalid,
  input  logic              ext_rerr
);
  rpath_e            st_q, st_d;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] ad_q, ad_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              rv_q, rv_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              re_q, re_d;
  logic              idle;

  assign idle      = (st_q == RP_IDLE);
  assign req_int   = idle && rmt_valid && hit;
  assign rmt_ready = idle && rmt_valid && (hit ? gnt : 1'b1);
  assign ext_rd    = (st_q == RP_XREQ) && !wr_q;
  assign ext_wr    = (st_q == RP_XREQ) &&  wr_q;
  assign ext_addr  = ad_q;
  assign ext_wdata = wd_q;
  assign rsp_valid = rv_q;
  assign rsp_rdata = rd_q;
  assign rsp_err   = re_q;

  always_comb begin
    st_d = st_q;
    wr_d = wr_q;
    ad_d = ad_q;
    wd_d = wd_q;
    rv_d = 1'b0;
    rd_d = '0;
    re_d = 1'b0;
    unique case (st_q)
      RP_IDLE: begin
        if (rmt_valid && !hit) begin
          st_d = RP_XREQ;
          wr_d = rmt_write;
          ad_d = rmt_addr;
          wd_d = rmt_wdata;
        end else if (gnt) begin
          rv_d = 1'b1;
          rd_d = rmt_write ? '0 : int_rdata;
        end
      end
      RP_XREQ: begin
        if (!ext_wait) begin
          if (wr_q) begin
            rv_d = 1'b1;
            st_d = RP_IDLE;
          end else begin
            st_d = RP_XRD;
          end
        end
      end
      RP_XRD: begin
        if (ext_rvalid) begin
          rv_d = 1'b1;
          rd_d = ext_rdata;
          re_d = ext_rerr;
          st_d = RP_IDLE;
        end
      end
      default: st_d = RP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RP_IDLE;
      wr_q <= 1'b0;
      ad_q <= '0;
      wd_q <= '0;
      rv_q <= 1'b0;
      rd_q <= '0;
      re_q <= 1'b0;
    end else begin
      st_q <= st_d;
      wr_q <= wr_d;
      ad_q <= ad_d;
      wd_q <= wd_d;
      rv_q <= rv_d;
      rd_q <= rd_d;
      re_q <= re_d;
    end
  end
endmodule

// File: rtl/cfg_route_top.sv
module cfg_route_top
  import cfg_route_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 32,
  parameter int REG_BASE = 32'h40,
  parameter int NREGS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcl_rd,
  input  logic              lcl_wr,
  input  logic [ADDR_W-1:0] lcl_addr,
  input  logic [DATA_W-1:0] lcl_wdata,
  output logic              lcl_wait,
  output logic [DATA_W-1:0] lcl_rdata,
  output logic              lcl_rvalid,
  output logic              lcl_rerr,
  input  logic              rmt_valid,
  input  logic              rmt_write,
  input  logic [ADDR_W-1:0] rmt_addr,
  input  logic [DATA_W-1:0] rmt_wdata,
  output logic              rmt_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic              ext_wait,
  input  logic [DATA_W-1:0] ext_rdata,
  input  logic              ext_rvalid,
  input  logic              ext_rerr
);
  localparam int IDX_W = $clog2(NREGS);

  logic              in_l, in_r, req_l, req_r, gnt_l, gnt_r, we;
  logic [IDX_W-1:0]  idx_l, idx_r, idx;
  logic [DATA_W-1:0] wdata, int_rdata;
  logic              lrv_q, lrv_d, lre_q, lre_d;
  logic [DATA_W-1:0] lrd_q, lrd_d;

  assign in_l  = in_window(32'(lcl_addr), 32'(REG_BASE), 32'(NREGS));
  assign in_r  = in_window(32'(rmt_addr), 32'(REG_BASE), 32'(NREGS));
  assign idx_l = IDX_W'(lcl_addr - ADDR_W'(REG_BASE));
  assign idx_r = IDX_W'(rmt_addr - ADDR_W'(REG_BASE));
  assign req_l = lcl_rd | lcl_wr;

  cfg_rr_arb i_arb (
    .clk(clk), .rst_n(rst_n), .req_l(req_l), .req_r(req_r),
    .gnt_l(gnt_l), .gnt_r(gnt_r)
  );

  assign lcl_wait = ~gnt_l;
  assign idx      = gnt_r ? idx_r : idx_l;
  assign wdata    = gnt_r ? rmt_wdata : lcl_wdata;
  assign we       = (gnt_l && lcl_wr && !lcl_rd && in_l) || (gnt_r && rmt_write);

  cfg_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) i_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .idx(idx), .wdata(wdata),
    .rdata(int_rdata)
  );

  cfg_rmt_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rmt (
    .clk(clk), .rst_n(rst_n),
    .rmt_valid(rmt_valid), .rmt_write(rmt_write), .rmt_addr(rmt_addr),
    .rmt_wdata(rmt_wdata), .hit(in_r), .gnt(gnt_r), .int_rdata(int_rdata),
    .req_int(req_r), .rmt_ready(rmt_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_wait(ext_wait), .ext_rdata(ext_rdata),
    .ext_rvalid(ext_rvalid), .ext_rerr(ext_rerr)
  );

  always_comb begin
    lrv_d = gnt_l && lcl_rd;
    lrd_d = (gnt_l && lcl_rd && in_l) ? int_rdata : '0;
    lre_d = gnt_l && lcl_rd && !in_l;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrv_q <= 1'b0;
      lrd_q <= '0;
      lre_q <= 1'b0;
    end else begin
      lrv_q <= lrv_d;
      lrd_q <= lrd_d;
      lre_q <= lre_d;
    end
  end

  assign lcl_rvalid = lrv_q;
  assign lcl_rdata  = lrd_q;
  assign lcl_rerr   = lre_q;
endmodule

// File: rtl/cfg_route_chk.sv
module cfg_route_chk
  import cfg_route_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 32,
  parameter int REG_BASE = 32'h40,
  parameter int NREGS    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lcl_rd,
  input logic              lcl_wr,
  input logic              lcl_wait,
  input logic              lcl_rvalid,
  input logic              lcl_rerr,
  input logic              rmt_valid,
  input logic [ADDR_W-1:0] rmt_addr,
  input logic              rmt_ready,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              ext_rd,
  input logic              ext_wr,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [DATA_W-1:0] ext_wdata,
  input logic              ext_wait
);
  logic l_acc, r_acc_int;
  assign l_acc     = (lcl_rd | lcl_wr) && !lcl_wait;
  assign r_acc_int = rmt_valid && rmt_ready &&
                     in_window(32'(rmt_addr), 32'(REG_BASE), 32'(NREGS));

  // R9
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_acc && r_acc_int));

  // R2
  lcl_rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_rd && !lcl_wait) |=> lcl_rvalid);

  // R10
  lcl_err_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_rerr |-> lcl_rvalid);

  // R10
  rsp_err_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  // R6
  rmt_int_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_acc_int |=> (rsp_valid && !rsp_err));

  // R7
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_rd || ext_wr) && ext_wait) |=>
      (ext_rd == $past(ext_rd)) && (ext_wr == $past(ext_wr)) &&
      $stable(ext_addr) && $stable(ext_wdata));

  // R7
  ext_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd || ext_wr) |->
      !in_window(32'(ext_addr), 32'(REG_BASE), 32'(NREGS)));

  // R8
  ext_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd || ext_wr) |-> !rmt_ready);
endmodule

bind cfg_route_top cfg_route_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_BASE(REG_BASE), .NREGS(NREGS)
) i_chk (.*);

// File: tb/test_cfg_route_top.sv
module test_cfg_route_top;
  localparam int BASE = 'h40;
  localparam int NR   = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lcl_rd, lcl_wr, lcl_wait, lcl_rvalid, lcl_rerr;
  logic [21:0] lcl_addr;
  logic [31:0] lcl_wdata, lcl_rdata;
  logic        rmt_valid, rmt_write, rmt_ready, rsp_valid, rsp_err;
  logic [21:0] rmt_addr;
  logic [31:0] rmt_wdata, rsp_rdata;
  logic        ext_rd, ext_wr, ext_wait, ext_rvalid, ext_rerr;
  logic [21:0] ext_addr;
  logic [31:0] ext_wdata, ext_rdata;

  int checks = 0, failures = 0, cyc = 0;
  logic [31:0] mdl [NR];
  int          wcnt = 0, rcnt = 0, cd = 0;
  logic [21:0] wa, ra;
  logic [31:0] wd;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cfg_route_top i_cfg_route_top (
    .clk(clk), .rst_n(rst_n),
    .lcl_rd(lcl_rd), .lcl_wr(lcl_wr), .lcl_addr(lcl_addr),
    .lcl_wdata(lcl_wdata), .lcl_wait(lcl_wait), .lcl_rdata(lcl_rdata),
    .lcl_rvalid(lcl_rvalid), .lcl_rerr(lcl_rerr),
    .rmt_valid(rmt_valid), .rmt_write(rmt_write), .rmt_addr(rmt_addr),
    .rmt_wdata(rmt_wdata), .rmt_ready(rmt_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_wait(ext_wait), .ext_rdata(ext_rdata),
    .ext_rvalid(ext_rvalid), .ext_rerr(ext_rerr)
  );

  function automatic logic [31:0] xdata(input logic [21:0] a);
    return {a, 10'h0} ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic xerr(input logic [21:0] a);
    return a[1:0] == 2'b11;
  endfunction
  function automatic logic inwin(input logic [21:0] a);
    return (a >= 22'(BASE)) && (a < 22'(BASE + NR));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // user-logic model on the master port
  initial begin
    ext_wait = 1'b0; ext_rvalid = 1'b0; ext_rdata = '0; ext_rerr = 1'b0;
    forever begin
      @(negedge clk);
      ext_rvalid = 1'b0; ext_rdata = '0; ext_rerr = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          ext_rvalid = 1'b1; ext_rdata = xdata(ra); ext_rerr = xerr(ra);
        end
      end
      ext_wait = ($urandom % 3) == 0;
      #1;
      if (ext_rd && !ext_wait && cd == 0) begin
        ra = ext_addr; rcnt++; cd = 1 + int'($urandom % 3);
      end
      if (ext_wr && !ext_wait) begin
        wa = ext_addr; wd = ext_wdata; wcnt++;
      end
    end
  end

  task automatic lw(input logic [21:0] a, input logic [31:0] d, output int acc);
    @(negedge clk);
    lcl_wr = 1'b1; lcl_addr = a; lcl_wdata = d;
    #1;
    while (lcl_wait) begin @(negedge clk); #1; end
    acc = cyc;
    @(negedge clk);
    lcl_wr = 1'b0;
  endtask

  task automatic lr(input logic [21:0] a, output logic v, output logic [31:0] d,
                    output logic e);
    @(negedge clk);
    lcl_rd = 1'b1; lcl_addr = a;
    #1;
    while (lcl_wait) begin @(negedge clk); #1; end
    @(negedge clk);
    lcl_rd = 1'b0;
    #1;
    v = lcl_rvalid; d = lcl_rdata; e = lcl_rerr;
    @(negedge clk); #1;
    chk("R2 rvalid single pulse", 32'(lcl_rvalid), 32'd0);
  endtask

  task automatic rq(input logic w, input logic [21:0] a, input logic [31:0] wdat,
                    output logic v, output logic [31:0] d, output logic e,
                    output int acc);
    int n;
    @(negedge clk);
    rmt_valid = 1'b1; rmt_write = w; rmt_addr = a; rmt_wdata = wdat;
    #1;
    while (!rmt_ready) begin @(negedge clk); #1; end
    acc = cyc;
    @(negedge clk);
    rmt_valid = 1'b0;
    #1;
    n = 0;
    while (!rsp_valid && n < 200) begin @(negedge clk); #1; n++; end
    v = rsp_valid; d = rsp_rdata; e = rsp_err;
  endtask

  task automatic lchk_read(input logic [21:0] a, input string req);
    logic v, e; logic [31:0] d;
    lr(a, v, d, e);
    chk({req, " valid"}, 32'(v), 32'd1);
    chk({req, " data"}, d, inwin(a) ? mdl[a - 22'(BASE)] : 32'd0);
    chk({req, " err"}, 32'(e), 32'(!inwin(a)));
  endtask

  initial begin
    int acc_l, acc_r, w0, r0;
    logic v, e; logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NR; i++) mdl[i] = '0;
    rst_n = 1'b0; lcl_rd = 0; lcl_wr = 0; lcl_addr = '0; lcl_wdata = '0;
    rmt_valid = 0; rmt_write = 0; rmt_addr = '0; rmt_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 lcl_rvalid in reset", 32'(lcl_rvalid), 32'd0);
    chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk("R1 master idle in reset", 32'({ext_rd, ext_wr}), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NR; i++) lchk_read(22'(BASE + i), "R1 reset value");

    // R3 basic write/read-back, both window edges
    lw(22'(BASE), 32'h1111_2222, acc_l); mdl[0] = 32'h1111_2222;
    lw(22'(BASE + NR - 1), 32'hCAFE_F00D, acc_l); mdl[NR-1] = 32'hCAFE_F00D;
    lchk_read(22'(BASE), "R3 low edge");
    lchk_read(22'(BASE + NR - 1), "R3 high edge");
    rq(1'b0, 22'(BASE + NR - 1), '0, v, d, e, acc_r);
    chk("R3 remote sees local write", d, 32'hCAFE_F00D);

    // R4 out-of-window local accesses, just past each edge
    w0 = wcnt; r0 = rcnt;
    lw(22'(BASE + NR), 32'hDEAD_BEEF, acc_l);
    lw(22'(BASE - 1), 32'hDEAD_BEEF, acc_l);
    lchk_read(22'(BASE + NR), "R4 read past window");
    lchk_read(22'(BASE), "R4 word 0 untouched");
    repeat (4) @(negedge clk);
    chk("R4 no master traffic", 32'(wcnt - w0 + rcnt - r0), 32'd0);

    // R9 / R5 contest after a local grant: remote must win
    lw(22'(BASE + 1), 32'h1, acc_l); mdl[1] = 32'h1;
    fork
      lw(22'(BASE + 2), 32'hAAAA_0001, acc_l);
      rq(1'b1, 22'(BASE + 2), 32'hBBBB_0001, v, d, e, acc_r);
    join
    chk("R9 remote wins after local", 32'(acc_r < acc_l), 32'd1);
    chk("R5 local held one cycle", 32'(acc_l - acc_r), 32'd1);
    mdl[2] = 32'hAAAA_0001;
    lchk_read(22'(BASE + 2), "R9 later writer kept");

    // R9 contest after a remote grant: local must win
    rq(1'b1, 22'(BASE + 3), 32'h3, v, d, e, acc_r); mdl[3] = 32'h3;
    chk("R6 write response data", d, 32'd0);
    fork
      lw(22'(BASE + 2), 32'hAAAA_0002, acc_l);
      rq(1'b1, 22'(BASE + 2), 32'hBBBB_0002, v, d, e, acc_r);
    join
    chk("R9 local wins after remote", 32'(acc_l < acc_r), 32'd1);
    mdl[2] = 32'hBBBB_0002;
    lchk_read(22'(BASE + 2), "R9 later writer kept");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op; logic [21:0] a; logic [31:0] dd;
      op = int'($urandom % 4);
      dd = $urandom;
      if (($urandom % 4) != 0) a = 22'(BASE + int'($urandom % NR));
      else begin
        a = 22'($urandom);
        if (inwin(a)) a = a + 22'h100;
      end
      case (op)
        0: begin
          lw(a, dd, acc_l);
          if (inwin(a)) mdl[a - 22'(BASE)] = dd;
        end
        1: lchk_read(a, inwin(a) ? "R2 random read" : "R4 random read");
        2: begin
          w0 = wcnt;
          rq(1'b1, a, dd, v, d, e, acc_r);
          chk("R6 R8 write response", {v, e, d == 32'd0}, {1'b1, 1'b0, 1'b1});
          if (inwin(a)) mdl[a - 22'(BASE)] = dd;
          else begin
            chk("R7 forwarded write count", 32'(wcnt - w0), 32'd1);
            chk("R7 forwarded write addr", 32'(wa), 32'(a));
            chk("R7 forwarded write data", wd, dd);
          end
        end
        default: begin
          rq(1'b0, a, '0, v, d, e, acc_r);
          chk("R6 R8 read response valid", 32'(v), 32'd1);
          if (inwin(a)) begin
            chk("R6 internal read data", d, mdl[a - 22'(BASE)]);
            chk("R6 internal read err", 32'(e), 32'd0);
          end else begin
            chk("R7 forwarded read addr", 32'(ra), 32'(a));
            chk("R8 forwarded read data", d, xdata(a));
            chk("R8 forwarded read err", 32'(e), 32'(xerr(a)));
          end
        end
      endcase
      @(negedge clk); #1;
      chk("R10 no stray error", 32'({lcl_rerr & ~lcl_rvalid, rsp_err & ~rsp_valid}), 32'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule